// File: doc/BRIEF.md
# Multi-speed data-strobe serializer

The block turns parallel words from a link-layer controller into a serial data-strobe stream for a cable port. It runs on one fast clock at eight times the system word rate. It makes a one-cycle word tick from that clock. On each tick it latches a new word whose width depends on the speed class: 2 bits at the lowest rate, 4 bits at the middle rate and 8 bits at the top rate. It then shifts the word out most significant bit first, at one bit every 4, 2 or 1 fast cycles. The word period is therefore always exactly filled.

A packet starts on the first tick at which transmit is requested while the port is not receiving. The speed class is fixed at that point and holds for the whole packet. The strobe line is driven so that exactly one of the data and strobe lines changes per bit. A receiver can recover the bit clock from their XOR.

Receive direction, power-down and the idle state all force both lines and the driver enable low.

Top module: `ds_serializer`

## Requirements
- R1: `sys_tick` is high for exactly one fast cycle in every eight while not powered down. The fast clock edge at the end of that cycle is the one at which `tx_en`, `speed` and `tx_data` are sampled.
- R2: The speed code selects the word width: 0 takes `tx_data[1:0]`, 1 takes `tx_data[3:0]`, and 2 or 3 both take `tx_data[7:0]`. Bits above the width are ignored. The most significant bit of the word is sent first.
- R3: A bit lasts 4 fast cycles at code 0, 2 at code 1 and 1 at codes 2 and 3. Bits of consecutive words follow with no gap.
- R4: `ser_data` carries the current bit. `ser_strobe` toggles exactly when the bit equals the previously sent bit, which counts as 0 at packet start, with the strobe at 0. So `ser_data ^ ser_strobe` changes once per bit.
- R5: While `rx_active` is high, `ser_data`, `ser_strobe` and `tx_drive` are 0 in the same cycle. A tick that sees `rx_active` high ends the packet.
- R6: The speed code is taken only on the tick that starts a packet. Changes to `speed` later in the packet have no effect.
- R7: Outside a packet, `ser_data`, `ser_strobe` and `tx_drive` are 0. `tx_drive` is high for exactly 8 fast cycles per word sent, covering every bit period.
- R8: While `pwr_down` is high, the outputs and `sys_tick` are 0 and any packet is dropped. After release, ticks resume.
- R9: After reset, all outputs are 0 until a packet starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit-rate clock, 8x the word rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Power-down: hold idle, stop ticks |
| tx_en | input | 1 | Transmit request, sampled at word ticks |
| rx_active | input | 1 | Port is receiving; transmit lines disabled |
| speed | input | 2 | Speed class for a new packet |
| tx_data | input | MAX_W | Parallel word from the link layer |
| sys_tick | output | 1 | Word tick, one cycle in eight |
| ser_data | output | 1 | Encoded data line |
| ser_strobe | output | 1 | Encoded strobe line |
| tx_drive | output | 1 | Line driver enable |

## Verification
A wrong phase count or bit-enable shows at the ports within one word period. The spacing between XOR transitions would drift away from 4, 2 or 1 cycles, or a word would come out truncated. A wrong shift-register load or strobe state corrupts the decoded bit sequence at the first affected bit, so decoding every packet at every speed exposes it within a few cycles. A stuck packet-active or speed register shows at the next word boundary: extra or missing `tx_drive` cycles, outputs not returning to 0, or words consumed at the wrong width after a mid-packet speed change.

// File: rtl/ds_serializer.sv
module ds_serializer #(
  parameter int MAX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_down,
  input  logic             tx_en,
  input  logic             rx_active,
  input  logic [1:0]       speed,
  input  logic [MAX_W-1:0] tx_data,
  output logic             sys_tick,
  output logic             ser_data,
  output logic             ser_strobe,
  output logic             tx_drive
);
  localparam int PH_W = $clog2(MAX_W);
  localparam int W_LO = MAX_W / 4;
  localparam int W_MD = MAX_W / 2;

  logic [PH_W-1:0]  ph;
  logic             active, drive_q, d_q, s_q;
  logic [1:0]       spd_q;
  logic [MAX_W-1:0] sh;
  logic [1:0]       spd_new;
  logic [PH_W-1:0]  step_mask;
  logic [MAX_W-1:0] word;
  logic             emit, tx_go;

  assign spd_new  = (speed == 2'd3) ? 2'd2 : speed;
  assign sys_tick = (ph == '1) && !pwr_down;
  assign tx_go    = tx_en && !rx_active;

  always_comb begin
    case (spd_q)
      2'd0:    step_mask = PH_W'(3);
      2'd1:    step_mask = PH_W'(1);
      default: step_mask = '0;
    endcase
  end

  always_comb begin
    case (active ? spd_q : spd_new)
      2'd0:    word = {tx_data[W_LO-1:0], {(MAX_W-W_LO){1'b0}}};
      2'd1:    word = {tx_data[W_MD-1:0], {(MAX_W-W_MD){1'b0}}};
      default: word = tx_data;
    endcase
  end

  assign emit = active && ((ph & step_mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0; active <= 1'b0; drive_q <= 1'b0;
      d_q <= 1'b0; s_q <= 1'b0; spd_q <= 2'd0; sh <= '0;
    end else if (pwr_down) begin
      ph <= '0; active <= 1'b0; drive_q <= 1'b0;
      d_q <= 1'b0; s_q <= 1'b0; sh <= '0;
    end else begin
      ph      <= ph + 1'b1;
      drive_q <= active;
      if (emit) begin
        d_q <= sh[MAX_W-1];
        s_q <= (sh[MAX_W-1] == d_q) ? !s_q : s_q;
        sh  <= sh << 1;
      end else if (!active) begin
        d_q <= 1'b0;
        s_q <= 1'b0;
      end
      if (sys_tick) begin
        if (tx_go) begin
          active <= 1'b1;
          if (!active) spd_q <= spd_new;
          sh <= word;
        end else begin
          active <= 1'b0;
        end
      end
    end
  end

  assign tx_drive   = drive_q && !rx_active && !pwr_down;
  assign ser_data   = d_q && tx_drive;
  assign ser_strobe = s_q && tx_drive;

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_tick |=> !sys_tick); // R1
  AST_DS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && !pwr_down) |=> ((d_q ^ s_q) != $past(d_q ^ s_q))); // R4
  AST_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active |-> (!ser_data && !ser_strobe && !tx_drive)); // R5
  AST_SPEED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !pwr_down) |=> $stable(spd_q)); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!d_q && !s_q)); // R7
  AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (ph == '0 && !active && !drive_q)); // R8
endmodule

// File: tb/ds_serializer_tb.sv
module ds_serializer_tb;
  logic clk = 1'b0, rst_n = 1'b0, pwr_down = 1'b0, tx_en = 1'b0, rx_active = 1'b0;
  logic [1:0] speed = 2'd0;
  logic [7:0] tx_data = 8'h00;
  logic sys_tick, ser_data, ser_strobe, tx_drive;

  always #4 clk = !clk;

  ds_serializer #(.MAX_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .tx_en(tx_en),
    .rx_active(rx_active), .speed(speed), .tx_data(tx_data),
    .sys_tick(sys_tick), .ser_data(ser_data), .ser_strobe(ser_strobe),
    .tx_drive(tx_drive));

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // {speed, word0, word1, word2}
  localparam logic [25:0] VEC [0:5] = '{
    {2'd0, 8'h01, 8'h02, 8'h03},
    {2'd1, 8'h0A, 8'h05, 8'h0F},
    {2'd2, 8'hA5, 8'h00, 8'hFF},
    {2'd3, 8'h3C, 8'h81, 8'h7E},
    {2'd0, 8'hFE, 8'hFD, 8'hFC},
    {2'd1, 8'hF0, 8'h00, 8'h33}
  };

  // decoder state
  int cyc = 0, cap_n = 0, exp_n = 0, exp_gap = 1, last_t = 0, gap_bad = 0, drive_cyc = 0;
  bit prev_x = 1'b0;
  bit cap_bits [0:23];
  bit exp_bits [0:23];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (tx_drive) drive_cyc = drive_cyc + 1;
    if ((ser_data ^ ser_strobe) != prev_x && cap_n < exp_n) begin
      cap_bits[cap_n] = ser_data;
      if (cap_n > 0 && (cyc - last_t) != exp_gap) gap_bad = gap_bad + 1;
      last_t = cyc;
      cap_n = cap_n + 1;
    end
    prev_x = ser_data ^ ser_strobe;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!sys_tick);
  endtask

  function automatic int width_of(input logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 4 : 8;
  endfunction

  task automatic send(input logic [1:0] s, input logic [7:0] w0, input logic [7:0] w1,
                      input logic [7:0] w2, input logic [1:0] s_later, input string tag);
    logic [7:0] ws [0:2];
    int w, n;
    ws[0] = w0; ws[1] = w1; ws[2] = w2;
    w = width_of(s);
    n = 0;
    for (int k = 0; k < 3; k++)
      for (int b = w - 1; b >= 0; b--) begin exp_bits[n] = ws[k][b]; n++; end
    exp_n = n; exp_gap = 8 / w; cap_n = 0; gap_bad = 0; drive_cyc = 0; prev_x = 1'b0;
    for (int k = 0; k < 3; k++) begin
      wait_tick();
      tx_en = 1'b1; tx_data = ws[k]; speed = (k == 0) ? s : s_later;
    end
    wait_tick();
    tx_en = 1'b0; tx_data = 8'h00;
    repeat (12) @(negedge clk);
    chk(cap_n == exp_n, "R2", {tag, " bit count"}, cap_n, exp_n);
    for (int i = 0; i < n; i++)
      if (cap_bits[i] != exp_bits[i]) begin
        chk(1'b0, "R4", {tag, " decoded bit"}, cap_bits[i], exp_bits[i]);
        break;
      end
    chk(gap_bad == 0, "R3", {tag, " bit period"}, gap_bad, 0);
    chk(drive_cyc == 24, "R7", {tag, " drive cycles"}, drive_cyc, 24);
    chk(!ser_data && !ser_strobe && !tx_drive, "R7", {tag, " idle after packet"},
        {ser_data, ser_strobe, tx_drive}, 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int ticks;
    int any;
    repeat (3) @(negedge clk);
    chk(!ser_data && !ser_strobe && !tx_drive && !sys_tick, "R9", "reset outputs",
        {ser_data, ser_strobe, tx_drive, sys_tick}, 0);
    rst_n = 1'b1;
    ticks = 0; any = 0;
    repeat (64) begin
      @(negedge clk);
      if (sys_tick) ticks++;
      if (ser_data || ser_strobe || tx_drive) any++;
    end
    chk(ticks == 8, "R1", "ticks per 64 cycles", ticks, 8);
    chk(any == 0, "R7", "idle without tx_en", any, 0);

    for (int v = 0; v < 6; v++)
      send(VEC[v][25:24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], VEC[v][25:24], "vector");

    // R6: speed changes after the first word are ignored
    send(2'd0, 8'hC6, 8'h5B, 8'h9E, 2'd2, "R6 speed change");
    send(2'd2, 8'h96, 8'h69, 8'h0F, 2'd0, "R6 speed change down");

    // R5: receive direction silences the port and ends the packet
    wait_tick(); tx_en = 1'b1; speed = 2'd2; tx_data = 8'hFF;
    repeat (3) @(negedge clk);
    chk(tx_drive == 1'b1, "R5", "drive before rx", tx_drive, 1);
    rx_active = 1'b1;
    #1;
    chk(!ser_data && !ser_strobe && !tx_drive, "R5", "outputs during rx",
        {ser_data, ser_strobe, tx_drive}, 0);
    wait_tick(); tx_en = 1'b0;
    repeat (2) @(negedge clk);
    rx_active = 1'b0;
    #1;
    chk(!ser_data && !ser_strobe && !tx_drive, "R5", "packet ended by rx",
        {ser_data, ser_strobe, tx_drive}, 0);

    // R8: power-down
    wait_tick(); tx_en = 1'b1; speed = 2'd1; tx_data = 8'h0F;
    repeat (4) @(negedge clk);
    pwr_down = 1'b1;
    #1;
    chk(!ser_data && !ser_strobe && !tx_drive, "R8", "outputs in power-down",
        {ser_data, ser_strobe, tx_drive}, 0);
    ticks = 0;
    repeat (20) begin @(negedge clk); if (sys_tick) ticks++; end
    chk(ticks == 0, "R8", "ticks in power-down", ticks, 0);
    tx_en = 1'b0;
    pwr_down = 1'b0;
    ticks = 0; any = 0;
    repeat (32) begin
      @(negedge clk);
      if (sys_tick) ticks++;
      if (ser_data || ser_strobe || tx_drive) any++;
    end
    chk(ticks == 4, "R8", "ticks after release", ticks, 4);
    chk(any == 0, "R8", "packet dropped by power-down", any, 0);

    send(2'd1, 8'h09, 8'h06, 8'h0C, 2'd1, "R3 after power-down");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule